// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Read Slave

This block models the slave side of a small two-wire serial EEPROM that a host operates by writing clock and data levels one at a time, for example through a pair of register bits. A pulse on `upd` tells the block that `scl_in` and `sda_in` now hold new levels. The block compares each update with the levels it recorded at the previous update. From that comparison it finds START and STOP conditions and data bits. It counts ticks through a command byte, an acknowledge slot and an address byte, and it shifts out the selected byte most significant bit first on `sda_out`.

The contents are a 256 x 8 array. A separate preload port fills the array, and reset does not clear it. Two-byte transfers are used in practice. A write-direction command followed by an address byte selects a location and fetches its byte. A later read-direction command returns that byte. The address does not advance after a read. `rd_bit` is the level the host reads back from the shared data line: the host's own level ANDed with the slave's driven level.

Top module: `i2c_bitbang_eeprom`

## Requirements
- R1: After a synchronous active-high reset, or during one, `sda_out` is 1 (released). The slave is idle and all counters and registers are cleared. Memory contents are kept.
- R2: An update in which SCL is high both before and after and SDA falls is a START. It arms the slave to receive a new command and leaves `sda_out` at 1. An update in which SCL is high both before and after and SDA rises is a STOP. It returns the slave to idle and sets `sda_out` to 1.
- R3: While idle (no START seen since reset or the last STOP), every other update is ignored: no bit is taken and `sda_out` stays 1.
- R4: A bit is taken only on an update where SCL goes from 0 to 1 and SDA is unchanged. An update that changes SDA together with a rising SCL is ignored. Updates with SCL low never change `sda_out`.
- R5: The first 8 bits after START form the command byte, MSB first. Only its bit 0 has meaning: 1 means read direction and 0 means write direction.
- R6: The 9th rising edge after START is the acknowledge slot, and it drives `sda_out` to 0. The next taken bit in write direction sets `sda_out` back to 1.
- R7: In write direction, the 8 bits after the acknowledge are shifted MSB first into the address register. On the 8th of them, the data register is loaded with the memory byte at the completed address.
- R8: In read direction, each of the 8 bits after the acknowledge sets `sda_out` to the current MSB of the data register and shifts that register left. On the 8th bit the data register is reloaded from the same address, with no increment.
- R9: After those 8 bits, further bits are ignored and `sda_out` holds until the next START or STOP.
- R10: `rd_bit` equals `sda_in` AND `sda_out`.
- R11: When `pl_we` is 1, the preload port writes `pl_data` to location `pl_addr` on a clock edge. Reset does not clear the contents.
- R12: In cycles with `upd` low, the block ignores `scl_in` and `sda_in`, and `sda_out` does not change.
- R13: A START in the middle of a transfer discards the partial command and restarts command reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Marks that `scl_in`/`sda_in` carry a new level update this cycle |
| scl_in | input | 1 | Sampled clock level from the host |
| sda_in | input | 1 | Sampled data level from the host |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 8 | Preload location |
| pl_data | input | 8 | Preload byte |
| sda_out | output | 1 | Slave data level, 1 when released |
| rd_bit | output | 1 | Wired-AND of host and slave data levels |

## Verification
A tick counter off by one shows at the ports as an acknowledge low on the wrong edge. It also shows as a returned byte shifted by one bit, and both appear within a single transfer of about 40 updates. A wrong address or data register shows up as a mismatch in the returned byte as soon as that location is read back. For this reason every one of the 256 locations is set and read back against a value computed from its index. Wrong edge classification shows up as ignored STARTs, spurious bits or a missing release, which make the next acknowledge or byte misalign.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    // Meaning of one sampled level update on the two wires.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_STOP  = 2'd2,
        EV_BIT   = 2'd3
    } bus_ev_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    localparam line_t LINE_IDLE = '{scl: 1'b1, sda: 1'b1};

    // Classify the transition from prev to cur.
    function automatic bus_ev_e classify(line_t prev, line_t cur);
        if (prev.scl && cur.scl && (prev.sda != cur.sda))
            return cur.sda ? EV_STOP : EV_START;
        if (!prev.scl && cur.scl && (prev.sda == cur.sda))
            return EV_BIT;
        return EV_NONE;
    endfunction

endpackage

// File: rtl/i2cs_line_tracker.sv
module i2cs_line_tracker
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    upd,
    input  line_t   cur,
    output line_t   prev,
    output bus_ev_e ev
);
    line_t prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= LINE_IDLE;
        else if (upd)
            prev_q <= cur;
    end

    assign prev = prev_q;
    assign ev   = upd ? classify(prev_q, cur) : EV_NONE;
endmodule

// File: rtl/i2cs_store.sv
module i2cs_store #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << BYTE_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Contents survive reset on purpose: only the preload port writes them.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2cs_sequencer.sv
module i2cs_sequencer
    import i2cs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ACK_TICK  = BYTE_W + 1,
    localparam int LAST_TICK = 2 * BYTE_W + 1,
    localparam int TICK_W    = $clog2(LAST_TICK + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_e           ev,
    input  logic              bit_in,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic [TICK_W-1:0] tick,
    output logic              sda_drv
);
    logic [TICK_W-1:0] tick_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic              sda_q;

    logic              is_read;
    logic              live;
    logic              payload;
    logic [BYTE_W-1:0] addr_nx;

    assign is_read = cmd_q[0];
    assign live    = (tick_q != '0) && (tick_q <= TICK_W'(LAST_TICK));
    assign payload = (tick_q > TICK_W'(ACK_TICK)) && (tick_q <= TICK_W'(LAST_TICK));

    always_comb begin
        addr_nx = addr_q;
        if (ev == EV_BIT && payload && !is_read)
            addr_nx = {addr_q[BYTE_W-2:0], bit_in};
    end

    assign rd_addr = addr_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            sda_q  <= 1'b1;
        end else begin
            case (ev)
                EV_START: begin
                    tick_q <= TICK_W'(1);
                    cmd_q  <= '0;
                    sda_q  <= 1'b1;
                end
                EV_STOP: begin
                    tick_q <= '0;
                    sda_q  <= 1'b1;
                end
                EV_BIT: begin
                    if (live) begin
                        tick_q <= tick_q + TICK_W'(1);
                        if (tick_q < TICK_W'(ACK_TICK)) begin
                            cmd_q <= {cmd_q[BYTE_W-2:0], bit_in};
                        end else if (tick_q == TICK_W'(ACK_TICK)) begin
                            sda_q <= 1'b0;
                        end else begin
                            addr_q <= addr_nx;
                            if (is_read) begin
                                sda_q  <= data_q[BYTE_W-1];
                                data_q <= {data_q[BYTE_W-2:0], 1'b0};
                            end else begin
                                sda_q <= 1'b1;
                            end
                            if (tick_q == TICK_W'(LAST_TICK))
                                data_q <= rd_data;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign tick    = tick_q;
    assign sda_drv = sda_q;
endmodule

// File: rtl/i2c_bitbang_eeprom.sv
module i2c_bitbang_eeprom
    import i2cs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int TICK_W = $clog2(2 * BYTE_W + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              pl_we,
    input  logic [BYTE_W-1:0] pl_addr,
    input  logic [BYTE_W-1:0] pl_data,
    output logic              sda_out,
    output logic              rd_bit
);
    line_t             cur_line;
    line_t             prev_line;
    bus_ev_e           ev;
    logic              prev_scl;
    logic              prev_sda;
    logic [BYTE_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_data;
    logic [TICK_W-1:0] seq_tick;

    assign cur_line = '{scl: scl_in, sda: sda_in};
    assign prev_scl = prev_line.scl;
    assign prev_sda = prev_line.sda;

    i2cs_line_tracker u_trk (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .cur  (cur_line),
        .prev (prev_line),
        .ev   (ev)
    );

    i2cs_sequencer #(.BYTE_W(BYTE_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .bit_in  (sda_in),
        .rd_data (mem_data),
        .rd_addr (mem_addr),
        .tick    (seq_tick),
        .sda_drv (sda_out)
    );

    i2cs_store #(.BYTE_W(BYTE_W)) u_mem (
        .clk     (clk),
        .wr_en   (pl_we),
        .wr_addr (pl_addr),
        .wr_data (pl_data),
        .rd_addr (mem_addr),
        .rd_data (mem_data)
    );

    assign rd_bit = sda_in & sda_out;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
    parameter int BYTE_W = 8,
    localparam int ACK_TICK  = BYTE_W + 1,
    localparam int LAST_TICK = 2 * BYTE_W + 1,
    localparam int TICK_W    = $clog2(LAST_TICK + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              upd,
    input logic              scl_in,
    input logic              sda_in,
    input logic              prev_scl,
    input logic              prev_sda,
    input logic              sda_out,
    input logic [TICK_W-1:0] tick
);
    logic cond_any;
    logic take;
    assign cond_any = upd && prev_scl && scl_in && (prev_sda != sda_in);
    assign take     = upd && !prev_scl && scl_in && (prev_sda == sda_in);

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        cond_any && sda_in |=> sda_out && tick == '0);                        // R2
    AST_START_ARM: assert property (@(posedge clk) disable iff (rst)
        cond_any && !sda_in |=> sda_out && tick == TICK_W'(1));               // R2
    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (rst)
        upd && tick == '0 && !cond_any |=> tick == '0 && sda_out);            // R3
    AST_LOW_SCL_HOLD: assert property (@(posedge clk) disable iff (rst)
        upd && !scl_in |=> $stable(sda_out));                                 // R4
    AST_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
        take && tick == TICK_W'(ACK_TICK) |=> !sda_out);                      // R6
    AST_AFTER_LAST_HOLD: assert property (@(posedge clk) disable iff (rst)
        upd && tick == TICK_W'(LAST_TICK + 1) && !cond_any
        |=> $stable(sda_out) && tick == TICK_W'(LAST_TICK + 1));              // R9
    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
        tick <= TICK_W'(LAST_TICK + 1));                                      // R9
    AST_NO_UPD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(sda_out) && $stable(tick));                          // R12
endmodule

bind i2c_bitbang_eeprom i2cs_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .prev_scl (prev_scl),
    .prev_sda (prev_sda),
    .sda_out  (sda_out),
    .tick     (seq_tick)
);

// File: tb/tb_i2c_bitbang_eeprom.sv
module tb_i2c_bitbang_eeprom;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_i = 1'b0, scl_i = 1'b1, sda_i = 1'b1;
    logic pl_we = 1'b0;
    logic [BW-1:0] pl_addr = '0, pl_data = '0;
    logic sda_out, rd_bit;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bitbang_eeprom #(.BYTE_W(BW)) dut (
        .clk(clk), .rst(rst), .upd(upd_i), .scl_in(scl_i), .sda_in(sda_i),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .sda_out(sda_out), .rd_bit(rd_bit)
    );

    function automatic logic [BW-1:0] pattern(input int a);
        return BW'((a * 37 + 11) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic d);
        @(negedge clk);
        scl_i = s; sda_i = d; upd_i = 1'b1;
        @(negedge clk);
        upd_i = 1'b0;
    endtask

    task automatic do_start;
        step(1, 1); step(1, 0); step(0, 0);
    endtask

    task automatic do_stop;
        step(0, 0); step(1, 0); step(1, 1);
    endtask

    task automatic send_bit(input logic b);
        step(0, b); step(1, b);
    endtask

    task automatic send_byte(input logic [BW-1:0] v);
        for (int i = BW - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic ack_slot;
        send_bit(1'b1);
        check(sda_out == 1'b0, "R6 ack drives low", sda_out, 0);
        check(rd_bit == 1'b0, "R10 wired-and during ack", rd_bit, 0);
    endtask

    task automatic read_byte(output logic [BW-1:0] v);
        for (int i = BW - 1; i >= 0; i--) begin
            send_bit(1'b1);
            v[i] = sda_out;
        end
    endtask

    task automatic set_addr(input logic [BW-1:0] cmd, input logic [BW-1:0] a);
        do_start; send_byte(cmd); ack_slot; send_byte(a); do_stop;
    endtask

    task automatic get_byte(input logic [BW-1:0] cmd, output logic [BW-1:0] v);
        do_start; send_byte(cmd); ack_slot; read_byte(v); do_stop;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [BW-1:0] got;
        // R11 preload every location while reset is held
        for (int a = 0; a < (1 << BW); a++) begin
            @(negedge clk);
            pl_we = 1'b1; pl_addr = BW'(a); pl_data = pattern(a);
        end
        @(negedge clk); pl_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sda_out == 1'b1, "R1 reset releases sda", sda_out, 1);
        check(rd_bit == 1'b1, "R10 rd_bit with both high", rd_bit, 1);

        // R3: clocking without a START does nothing
        for (int i = 0; i < 9; i++) send_bit(1'b0);
        check(sda_out == 1'b1, "R3 idle ignores bits", sda_out, 1);
        check(rd_bit == 1'b0, "R10 host low pulls rd_bit low", rd_bit, 0);

        // R5 R6 R7 R8: sweep every location
        for (int a = 0; a < (1 << BW); a++) begin
            set_addr(8'hA0, BW'(a));
            get_byte(8'hA1, got);
            check(got == pattern(a), "R7 R8 byte readback", got, pattern(a));
        end

        // R6 release after ack in write direction
        do_start; send_byte(8'hA0); ack_slot;
        send_bit(1'b0);
        check(sda_out == 1'b1, "R6 release after ack", sda_out, 1);
        for (int i = 0; i < BW - 1; i++) send_bit(1'b1);
        do_stop;
        // R5: only bit 0 of the command matters
        set_addr(8'h5E, 8'd1);
        get_byte(8'h01, got);
        check(got == pattern(1), "R5 command bit0 only", got, pattern(1));

        // R9: extra bits after the byte leave sda_out holding (last bit of 0x30 is 0)
        do_start; send_byte(8'hA1); ack_slot; read_byte(got);
        check(got == pattern(1), "R8 byte before extras", got, pattern(1));
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        check(sda_out == 1'b0, "R9 extra bits ignored", sda_out, 0);
        do_stop;
        check(sda_out == 1'b1, "R2 stop releases", sda_out, 1);

        // R13: repeated start mid-command
        do_start;
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        step(0, 1); step(1, 1); step(1, 0); step(0, 0);
        send_byte(8'hA1); ack_slot; read_byte(got); do_stop;
        check(got == pattern(1), "R13 repeated start", got, pattern(1));

        // R4: rising SCL with SDA change is ignored
        set_addr(8'hA0, 8'd2);
        do_start; step(0, 0); step(1, 1);
        send_byte(8'hA1);
        check(sda_out == 1'b1, "R4 glitch edge not counted", sda_out, 1);
        ack_slot; read_byte(got); do_stop;
        check(got == pattern(2), "R4 read after glitch", got, pattern(2));

        // R12: pin activity without upd is ignored
        do_start; send_byte(8'hA1); ack_slot;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); scl_i = ~scl_i; sda_i = (i % 3) == 0;
        end
        @(negedge clk);
        check(sda_out == 1'b0, "R12 no update holds", sda_out, 0);
        scl_i = 1'b1; sda_i = 1'b1;
        read_byte(got); do_stop;
        check(got == pattern(2), "R12 read intact", got, pattern(2));

        // R1: reset in the ack slot releases
        do_start; send_byte(8'hA1); ack_slot;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(sda_out == 1'b1, "R1 reset mid-transfer", sda_out, 1);
        scl_i = 1'b1; sda_i = 1'b1;

        // R11: contents survive reset, then overwrite one location
        set_addr(8'hA0, 8'd5);
        get_byte(8'hA1, got);
        check(got == pattern(5), "R11 kept over reset", got, pattern(5));
        @(negedge clk); pl_we = 1'b1; pl_addr = 8'd5; pl_data = 8'h3C;
        @(negedge clk); pl_we = 1'b0;
        set_addr(8'hA0, 8'd5);
        get_byte(8'hA1, got);
        check(got == 8'h3C, "R11 preload overwrite", got, 8'h3C);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule